// File: doc/BRIEF.md
# Serial Bit Stuffer and Destuffer

This block maintains the run-length rule of a serial bus on both paths of one node. On the transmit path it accepts payload bits through a ready/valid handshake and drives line bits. When the last five line bits have all had the same level, it sends one bit of the opposite level and holds off the payload for that bit-time. On the receive path it takes line bits and passes the payload bits on with a valid flag. It drops the bit that follows five equal bits, and it reports an error when that bit breaks the rule.

All activity advances on a single-cycle bit-time strobe. A frame-zone input marks the span from start-of-frame through the end of the CRC field. Stuffing and destuffing apply only inside that span, for data frames and remote frames alike. Outside it, bits pass straight through and both run counters are held clear.

Top module: `bit_stuff_codec`

## Requirements
- R1: After reset, tx_line is 1, tx_ready is 1, rx_valid is 0 and rx_stuff_err is 0.
- R2: tx_line, rx_data, rx_valid and rx_stuff_err change only on a clock edge where bit_stb is 1. Each value holds for the whole bit-time that follows.
- R3: While frame_zone is 1 and the last five transmitted bits have equal level, tx_ready is 0. The next strobe then drives tx_line to the opposite level and consumes no payload bit.
- R4: A transmitted stuff bit counts as the first bit of a new run. Four further payload bits of that same level therefore produce another stuff bit.
- R5: When frame_zone is 0, a strobe with tx_valid at 1 copies tx_bit to tx_line and no stuff bit is ever sent. Both run counters are cleared, so counting starts afresh when the zone opens.
- R6: A strobe with tx_valid at 0 and no stuff bit due drives tx_line to 1 and clears the transmit run.
- R7: While frame_zone is 1, the received bit that follows five equal bits is deleted. In that bit-time rx_valid is 0.
- R8: If that deleted bit has the same level as the five before it, rx_stuff_err is 1 for that one bit-time and 0 in every other bit-time. The deleted bit then counts as a run of one.
- R9: Every received bit that is not deleted appears on rx_data with rx_valid at 1 in the bit-time after its strobe. Outside the zone, every bit is passed.
- R10: A deleted stuff bit starts a new receive run of length one. Four more bits of its level followed by a fifth deleted bit are handled as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a bit boundary |
| frame_zone | input | 1 | High from start-of-frame through end of CRC field |
| tx_bit | input | 1 | Payload bit offered for transmission |
| tx_valid | input | 1 | tx_bit is valid |
| tx_ready | output | 1 | Payload bit is consumed at the next strobe |
| tx_line | output | 1 | Transmitted line bit |
| rx_line | input | 1 | Received line bit, sampled at the strobe |
| rx_data | output | 1 | Received payload bit |
| rx_valid | output | 1 | rx_data holds a payload bit for this bit-time |
| rx_stuff_err | output | 1 | Stuff rule violated in this bit-time |

## Verification
The embedded properties check every clock for the following:
- Both run counters stay within the limit.
- A stalled strobe always flips the line level.
- Outputs never move between strobes.
- An error never coincides with valid data.
- Ready is only withdrawn inside the zone.

Only the bench scenarios can show the following:
- Where stuff bits fall in long mixed streams.
- That a run restarts at a stuff bit (R4, R10).
- That counting restarts correctly when the zone closes and reopens.
- That payload bits are neither lost nor repeated across stalls.

// File: rtl/bit_stuff_codec.sv
module bit_stuff_codec #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic frame_zone,
  input  logic tx_bit,
  input  logic tx_valid,
  output logic tx_ready,
  output logic tx_line,
  input  logic rx_line,
  output logic rx_data,
  output logic rx_valid,
  output logic rx_stuff_err
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] tx_run, rx_run;
  logic tx_last, rx_last;

  wire tx_stuff = frame_zone && (tx_run == FULL);
  wire rx_stuff = frame_zone && (rx_run == FULL);
  assign tx_ready = !tx_stuff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run  <= '0;
      tx_last <= 1'b1;
      tx_line <= 1'b1;
    end else if (!frame_zone) begin
      tx_run <= '0;
      if (bit_stb) tx_line <= tx_valid ? tx_bit : 1'b1;
    end else if (bit_stb) begin
      if (tx_stuff) begin
        tx_line <= ~tx_last;
        tx_last <= ~tx_last;
        tx_run  <= ONE;
      end else if (tx_valid) begin
        tx_line <= tx_bit;
        tx_last <= tx_bit;
        tx_run  <= (tx_run != '0 && tx_bit == tx_last) ? tx_run + ONE : ONE;
      end else begin
        tx_line <= 1'b1;
        tx_run  <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_run       <= '0;
      rx_last      <= 1'b1;
      rx_data      <= 1'b1;
      rx_valid     <= 1'b0;
      rx_stuff_err <= 1'b0;
    end else if (bit_stb) begin
      rx_data <= rx_line;
      rx_last <= rx_line;
      if (!frame_zone) begin
        rx_valid     <= 1'b1;
        rx_stuff_err <= 1'b0;
        rx_run       <= '0;
      end else if (rx_stuff) begin
        rx_valid     <= 1'b0;
        rx_stuff_err <= (rx_line == rx_last);
        rx_run       <= ONE;
      end else begin
        rx_valid     <= 1'b1;
        rx_stuff_err <= 1'b0;
        rx_run       <= (rx_run != '0 && rx_line == rx_last) ? rx_run + ONE : ONE;
      end
    end else if (!frame_zone) begin
      rx_run <= '0;
    end
  end

  AST_TX_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_run <= FULL);                                                        // R3
  AST_RX_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_run <= FULL);                                                        // R7
  AST_STUFF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !tx_ready) |=> (tx_line != $past(tx_line)));                // R3
  AST_STALL_IN_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> frame_zone);                                              // R5
  AST_HOLD_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(tx_line));                                         // R2
  AST_HOLD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(rx_valid) && $stable(rx_data) && $stable(rx_stuff_err))); // R2
  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> !rx_valid);                                            // R8
endmodule

// File: tb/sim_bit_stuff_codec.sv
`timescale 1ns/1ps
module sim_bit_stuff_codec;
  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, frame_zone = 1'b0;
  logic tx_bit = 1'b0, tx_valid = 1'b0, rx_line = 1'b1;
  logic tx_ready, tx_line, rx_data, rx_valid, rx_stuff_err;

  bit_stuff_codec #(.RUN_LEN(5)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_zone(frame_zone),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid), .rx_stuff_err(rx_stuff_err));

  always #2.5 clk = ~clk;

  int vec = 0, bad = 0;
  bit finished = 1'b0;
  int m_trun = 0, m_rrun = 0;
  logic m_tlast = 1'b1, m_rlast = 1'b1;
  bit m_tafter = 1'b0, m_rafter = 1'b0;
  int consumed = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_ready(input logic zone);
    return !(zone && m_trun == 5);
  endfunction

  function automatic int next_run(input int run, input logic last, input logic b);
    return (run != 0 && b == last) ? run + 1 : 1;
  endfunction

  task automatic bit_time(input logic zone, input logic tb, input logic tv, input logic rl);
    logic e_line, e_rv, e_re, e_rd, e_rdy;
    string ttag, rtag;
    @(negedge clk);
    frame_zone = zone; tx_bit = tb; tx_valid = tv; rx_line = rl; bit_stb = 1'b1;
    e_rdy = exp_ready(zone);
    #0.5;
    chk(e_rdy ? "R3 ready high" : "R3 ready low", tx_ready, e_rdy);
    if (!zone) begin
      e_line = tv ? tb : 1'b1; ttag = tv ? "R5" : "R6"; m_trun = 0;
      if (tv) consumed++;
      m_tafter = 1'b0;
    end else if (m_trun == 5) begin
      e_line = ~m_tlast; m_tlast = e_line; m_trun = 1; ttag = "R3"; m_tafter = 1'b1;
    end else if (tv) begin
      e_line = tb; ttag = m_tafter ? "R4" : "R3";
      m_trun = next_run(m_trun, m_tlast, tb); m_tlast = tb; consumed++;
    end else begin
      e_line = 1'b1; ttag = "R6"; m_trun = 0; m_tafter = 1'b0;
    end
    e_rd = rl;
    if (!zone) begin
      e_rv = 1'b1; e_re = 1'b0; m_rrun = 0; rtag = "R9"; m_rafter = 1'b0;
    end else if (m_rrun == 5) begin
      e_rv = 1'b0; e_re = (rl == m_rlast); m_rrun = 1;
      rtag = e_re ? "R8" : "R7"; m_rafter = 1'b1;
    end else begin
      e_rv = 1'b1; e_re = 1'b0; rtag = m_rafter ? "R10" : "R9";
      m_rrun = next_run(m_rrun, m_rlast, rl);
    end
    m_rlast = rl;
    @(negedge clk);
    bit_stb = 1'b0;
    chk({ttag, " tx_line"}, tx_line, e_line);
    chk({rtag, " rx_valid"}, rx_valid, e_rv);
    chk(e_re ? "R8 err high" : "R8 err low", rx_stuff_err, e_re);
    if (e_rv) chk({rtag, " rx_data"}, rx_data, e_rd);
    @(negedge clk);
    @(negedge clk);
    chk("R2 tx_line hold", tx_line, e_line);
    chk("R2 rx_valid hold", rx_valid, e_rv);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic zone, tb, rl;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_line", tx_line, 1'b1);
    chk("R1 tx_ready", tx_ready, 1'b1);
    chk("R1 rx_valid", rx_valid, 1'b0);
    chk("R1 rx_stuff_err", rx_stuff_err, 1'b0);

    for (int i = 0; i < 7; i++) bit_time(1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) bit_time(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) bit_time(1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) bit_time(1'b1, 1'b0, 1'b1, 1'b1);
    bit_time(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) bit_time(1'b1, 1'b1, 1'b1, 1'b0);
    bit_time(1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) bit_time(1'b1, 1'b0, 1'b0, 1'b1);
    bit_time(1'b0, 1'b1, 1'b1, 1'b1);

    zone = 1'b1; tb = 1'b0; rl = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 100 < 3) zone = ~zone;
      if ($urandom % 100 >= 80) tb = ~tb;
      if ($urandom % 100 >= 82) rl = ~rl;
      bit_time(zone, tb, ($urandom % 100) < 95, rl);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule